// File: doc/BRIEF.md
# Bridge Fault Supervisor

This block decides, on every clock, whether the power stage of a full H-bridge may conduct. It takes the digital flags of the protection sensors: an overcurrent flag, a supply-undervoltage flag, an overtemperature flag and a standby indication. It drives a bridge-disable line and an active-low fault line meant for an open-drain pad. An overcurrent trip is handled in one of two ways, and a mode input picks the way. In the timed-retry way the bridge is shut off for a fixed number of cycles and is then switched on again to test whether the short is still there. In the latched way the bridge stays off until the device leaves standby or until reset, which stands for a cycle of the supply.

Each time the bridge switches on, a blanking window starts. During this window the overcurrent flag is not acted on, so that switching transients are not taken for a short. The undervoltage, overtemperature and standby inputs hold the bridge off while they are active, and they do not set the fault line. Any hysteresis on these flags is applied before they reach this block. Both the timeout and the blanking length are parameters in clock cycles. The default timeout is 2 ms at a 100 MHz clock.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: While reset is active, bridge_off is 1 and fault_n is 1. At the first clock edge after reset is released, with no hold flag active, bridge_off goes to 0.
- R2: If uv_flag, ot_flag or standby is 1 at a clock edge, bridge_off is 1 after that edge. Once all three are 0, the bridge is enabled again at the next edge, unless an overcurrent condition keeps it off. These flags never change fault_n.
- R3: oc_detect is ignored at the first BLANK_CYC clock edges after the edge that switched the bridge on (bridge_off going from 1 to 0).
- R4: With latch_mode = 0, an accepted overcurrent drives bridge_off to 1 at the next edge. bridge_off then stays 1 for exactly TIMEOUT_CYC cycles and then returns to 0, provided no hold flag is active.
- R5: With latch_mode = 1, an accepted overcurrent drives bridge_off to 1 and fault_n to 0. Both stay that way for any number of cycles, however long the retry timeout.
- R6: A latched shutdown is released only at the clock edge where standby is seen 0 after having been 1 at the previous edge. Undervoltage and overtemperature activity do not release it. At the release edge fault_n returns to 1 and the bridge is enabled.
- R7: fault_n goes to 0 at the edge after an accepted overcurrent. In retry mode it stays 0 for the whole timeout and the following blanking window. It returns to 1 at the first edge after blanking where oc_detect is 0.
- R8: In retry mode, if oc_detect is still 1 when blanking ends after a retry, a new trip follows at once and fault_n never returns to 1 in between.
- R9: latch_mode is sampled only at the edge where the overcurrent is accepted. Changing it during a timeout does not change the outcome of that trip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, also models a supply cycle |
| oc_detect | input | 1 | Overcurrent flag from the current comparator |
| latch_mode | input | 1 | 0: timed retry, 1: latched shutdown (an open pin reads as 1) |
| uv_flag | input | 1 | Supply undervoltage flag |
| ot_flag | input | 1 | Overtemperature flag, with hysteresis applied upstream |
| standby | input | 1 | High while the device is in low-power standby |
| bridge_off | output | 1 | 1 disables all bridge outputs |
| fault_n | output | 1 | Active-low overcurrent fault indication |

## Verification
The collisions that matter most are between the end of a blanking window and a new overcurrent flag, and between the end of the retry timeout and a hold flag or a mode change. Directed sequences hold oc_detect high across the exact edge where blanking ends. They also toggle latch_mode in the middle of a timeout and release standby during a latched shutdown. Randomized traffic then layers hold flags, standby pulses and mode flips over overcurrent pulses. Each cycle is judged against a bench model that counts cycles since switch-on and cycles of timeout left.

// File: rtl/ocf_pkg.sv
package ocf_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_WAIT  = 2'd1,
    ST_LATCH = 2'd2
  } ocf_state_e;

  // bits needed to hold values 0..maxval
  function automatic int unsigned cnt_bits(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

  // reload value of the retry counter: the off time counts the load cycle
  function automatic int unsigned retry_reload(input int unsigned timeout);
    return (timeout == 0) ? 0 : timeout - 1;
  endfunction

endpackage

// File: rtl/ocf_blank_timer.sv
module ocf_blank_timer
  import ocf_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);

  localparam int unsigned W = cnt_bits(BLANK_CYC);
  localparam logic [W-1:0] LOADV = W'(BLANK_CYC);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= LOADV;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  // R3
  blank_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOADV);

  generate
    if (BLANK_CYC > 0) begin : g_start_chk
      // R3
      blank_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active);
    end
  endgenerate

endmodule

// File: rtl/ocf_retry_timer.sv
module ocf_retry_timer
  import ocf_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int unsigned W = cnt_bits(TIMEOUT_CYC);
  localparam logic [W-1:0] RELOAD = W'(retry_reload(TIMEOUT_CYC));

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= RELOAD;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R4
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= RELOAD);

  generate
    if (TIMEOUT_CYC > 1) begin : g_load_chk
      // R4
      timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);
    end
  endgenerate

endmodule

// File: rtl/ocf_fault_fsm.sv
module ocf_fault_fsm
  import ocf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oc_evt,
  input  logic       latch_sel,
  input  logic       stby_exit,
  input  logic       timer_expired,
  input  logic       clean_on,
  output ocf_state_e state,
  output ocf_state_e st_nxt,
  output logic       retry_load,
  output logic       fault_q
);

  always_comb begin
    st_nxt = state;
    unique case (state)
      ST_ARMED: if (oc_evt)        st_nxt = latch_sel ? ST_LATCH : ST_WAIT;
      ST_WAIT:  if (timer_expired) st_nxt = ST_ARMED;
      ST_LATCH: if (stby_exit)     st_nxt = ST_ARMED;
      default:                     st_nxt = ST_ARMED;
    endcase
  end

  assign retry_load = (state == ST_ARMED) && oc_evt && !latch_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_ARMED;
      fault_q <= 1'b0;
    end else begin
      state <= st_nxt;
      if (oc_evt)                               fault_q <= 1'b1;
      else if (state == ST_LATCH && stby_exit)  fault_q <= 1'b0;
      else if (clean_on)                        fault_q <= 1'b0;
    end
  end

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LATCH && !stby_exit) |=> state == ST_LATCH);

  // R6
  latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LATCH && stby_exit) |=> (state == ST_ARMED && !fault_q));

  // R7
  fault_while_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_ARMED) |-> fault_q);

endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor
  import ocf_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 200000,
  parameter int unsigned BLANK_CYC   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_detect,
  input  logic latch_mode,
  input  logic uv_flag,
  input  logic ot_flag,
  input  logic standby,
  output logic bridge_off,
  output logic fault_n
);

  ocf_state_e state, st_nxt;
  logic bridge_off_q, stby_q;
  logic hold, enable_nxt, turn_on;
  logic blank_active, oc_evt, clean_on, stby_exit;
  logic retry_load, timer_expired, fault_q;

  assign hold       = uv_flag || ot_flag || standby;
  assign stby_exit  = stby_q && !standby;
  assign enable_nxt = (st_nxt == ST_ARMED) && !hold;
  assign turn_on    = bridge_off_q && enable_nxt;
  assign oc_evt     = oc_detect && !bridge_off_q && !blank_active;
  assign clean_on   = !oc_detect && !bridge_off_q && !blank_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bridge_off_q <= 1'b1;
      stby_q       <= 1'b0;
    end else begin
      bridge_off_q <= !enable_nxt;
      stby_q       <= standby;
    end
  end

  ocf_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (turn_on),
    .active (blank_active)
  );

  ocf_retry_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_retry (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (retry_load),
    .run     (state == ST_WAIT),
    .expired (timer_expired)
  );

  ocf_fault_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .oc_evt        (oc_evt),
    .latch_sel     (latch_mode),
    .stby_exit     (stby_exit),
    .timer_expired (timer_expired),
    .clean_on      (clean_on),
    .state         (state),
    .st_nxt        (st_nxt),
    .retry_load    (retry_load),
    .fault_q       (fault_q)
  );

  assign bridge_off = bridge_off_q;
  assign fault_n    = !fault_q;

  // R2
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_flag || ot_flag || standby) |=> bridge_off);

  // R4
  retry_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_load |=> (bridge_off && state == ST_WAIT));

  // R7
  trip_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_evt |=> !fault_n);

  // R5
  latch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LATCH) |-> bridge_off);

  generate
    if (BLANK_CYC > 0) begin : g_blank_on_chk
      // R3
      blank_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bridge_off) |-> blank_active);
    end
  endgenerate

endmodule

// File: tb/sim_bridge_fault_supervisor.sv
module sim_bridge_fault_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;
  localparam int BLK = 5;

  logic clk, rst_n, oc_detect, latch_mode, uv_flag, ot_flag, standby;
  logic bridge_off, fault_n;

  int n_chk = 0;
  int n_fail = 0;

  bridge_fault_supervisor #(.TIMEOUT_CYC(TMO), .BLANK_CYC(BLK)) u0 (
    .clk(clk), .rst_n(rst_n), .oc_detect(oc_detect), .latch_mode(latch_mode),
    .uv_flag(uv_flag), .ot_flag(ot_flag), .standby(standby),
    .bridge_off(bridge_off), .fault_n(fault_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: cycles since switch-on and cycles of timeout left
  logic m_off, m_flt, m_lat, m_sprev;
  int   m_wait, m_age;
  logic f_hold, f_trip, f_clean, f_exit, f_newoff;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_off = 1'b1; m_flt = 1'b0; m_lat = 1'b0; m_sprev = 1'b0;
      m_wait = 0; m_age = BLK;
    end else begin
      f_hold  = uv_flag | ot_flag | standby;
      f_trip  = !m_off && (m_age >= BLK) && oc_detect;
      f_clean = !m_off && (m_age >= BLK) && !oc_detect;
      f_exit  = m_sprev && !standby;
      if (f_trip) begin
        if (latch_mode) m_lat = 1'b1;
        else            m_wait = TMO;
        m_flt = 1'b1;
      end else begin
        if (m_wait > 0) m_wait = m_wait - 1;
        if (m_lat && f_exit) begin m_lat = 1'b0; m_flt = 1'b0; end
        else if (f_clean) m_flt = 1'b0;
      end
      f_newoff = m_lat || (m_wait != 0) || f_hold;
      if (m_off && !f_newoff) m_age = 0;
      else if (m_age < BLK)   m_age = m_age + 1;
      m_off = f_newoff;
      m_sprev = standby;
    end
  end

  function automatic string mtag();
    if (!rst_n)      return "R1";
    if (m_lat)       return "R5";
    if (m_wait != 0) return "R4";
    if (m_flt)       return "R7";
    return "R2";
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(mtag(), bridge_off, m_off, "bridge_off vs model");
    chk(mtag(), fault_n, !m_flt, "fault_n vs model");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; oc_detect = 1'b0; latch_mode = 1'b0;
    uv_flag = 1'b0; ot_flag = 1'b0; standby = 1'b0;
    repeat (3) tick();
    chk("R1", bridge_off, 1'b1, "off in reset");
    chk("R1", fault_n, 1'b1, "no fault in reset");
    rst_n = 1'b1;
    tick();
    chk("R1", bridge_off, 1'b0, "enabled after reset");

    // R3: flag held through the blanking window is ignored
    oc_detect = 1'b1;
    repeat (BLK) tick();
    chk("R3", bridge_off, 1'b0, "still on after blanked flag");
    chk("R3", fault_n, 1'b1, "no fault during blanking");
    tick();
    chk("R4", bridge_off, 1'b1, "off after trip");
    chk("R7", fault_n, 1'b0, "fault at trip");
    oc_detect = 1'b0;
    latch_mode = 1'b1;               // R9: change during timeout
    repeat (TMO - 1) tick();
    chk("R4", bridge_off, 1'b1, "still off at last timeout cycle");
    tick();
    chk("R9", bridge_off, 1'b0, "retry despite mode change");
    chk("R7", fault_n, 1'b0, "fault held at retry");
    latch_mode = 1'b0;
    repeat (BLK) tick();
    chk("R7", fault_n, 1'b0, "fault held through blanking");
    tick();
    chk("R7", fault_n, 1'b1, "fault released when clean");

    // R8: short persists across the retry
    oc_detect = 1'b1;
    tick();
    chk("R8", bridge_off, 1'b1, "first trip");
    repeat (TMO) tick();
    chk("R8", bridge_off, 1'b0, "retry on");
    chk("R8", fault_n, 1'b0, "fault kept on retry");
    repeat (BLK) tick();
    chk("R8", fault_n, 1'b0, "fault kept at blank end");
    tick();
    chk("R8", bridge_off, 1'b1, "second trip");
    chk("R8", fault_n, 1'b0, "fault never released");
    oc_detect = 1'b0;
    repeat (TMO) tick();
    repeat (BLK + 1) tick();
    chk("R7", fault_n, 1'b1, "released after clean retry");

    // R2: hold flags
    uv_flag = 1'b1;
    tick();
    chk("R2", bridge_off, 1'b1, "undervoltage holds off");
    chk("R2", fault_n, 1'b1, "undervoltage no fault");
    uv_flag = 1'b0;
    tick();
    chk("R2", bridge_off, 1'b0, "on after undervoltage");
    ot_flag = 1'b1;
    repeat (4) tick();
    chk("R2", bridge_off, 1'b1, "overtemp holds off");
    ot_flag = 1'b0;
    tick();
    chk("R2", bridge_off, 1'b0, "on after overtemp");

    // R5 / R6: latched shutdown
    repeat (BLK) tick();
    latch_mode = 1'b1;
    oc_detect = 1'b1;
    tick();
    chk("R5", bridge_off, 1'b1, "latched off");
    oc_detect = 1'b0;
    repeat (3 * TMO) tick();
    chk("R5", bridge_off, 1'b1, "latch outlasts timeout");
    chk("R5", fault_n, 1'b0, "latched fault");
    uv_flag = 1'b1; ot_flag = 1'b1;
    tick();
    uv_flag = 1'b0; ot_flag = 1'b0;
    repeat (2) tick();
    chk("R6", bridge_off, 1'b1, "flags do not release latch");
    standby = 1'b1;
    repeat (5) tick();
    chk("R6", bridge_off, 1'b1, "off during standby");
    standby = 1'b0;
    tick();
    chk("R6", bridge_off, 1'b0, "released on standby exit");
    chk("R6", fault_n, 1'b1, "fault cleared on standby exit");

    // randomized traffic against the model
    latch_mode = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      oc_detect = ($urandom % 8) == 0;
      uv_flag   = ($urandom % 40) == 0;
      ot_flag   = ($urandom % 50) == 0;
      if (($urandom % 60) == 0)  standby = !standby;
      if (($urandom % 200) == 0) latch_mode = !latch_mode;
      tick();
    end

    summary();
    $finish;
  end

endmodule